// File: doc/BRIEF.md
# Serial Memory Front-End Control

This block is the control front end of a serial memory device. It samples the chip-select, serial clock and serial data lines against a faster system clock. From them it tracks whether a transfer frame is open and captures the first byte of each frame as a command byte. A frame that opens and closes with no serial clock edges inside it is treated as an interface reset. After such a frame the next byte shifted in starts a new command.

The block also holds the status register and decides whether write requests are allowed. The register's volatile part is a busy flag and a write-enable latch. Its nonvolatile part is a protect-enable bit and a two-bit region-protect code. A power-on reset clears only the volatile part. The nonvolatile bits change only through a granted status write or a factory-init pulse.

A requested array write is granted when the latch is set, no write is in progress, and the address lies outside the protected region. A requested status write is granted when the latch is set and no write is in progress, unless protect-enable is set and the write-protect pin is low. A grant starts a write, and a done pulse ends it.

Top module: `spi_mem_ctl`

## Requirements
- R1: A power-on reset clears busy and the write-enable latch and both grant outputs, and leaves the protect-enable and region-protect bits at their previous values.
- R2: A factory-init pulse sets protect-enable to 0 and the region-protect code to 00.
- R3: A frame opens only on a high-to-low chip-select transition seen after reset. If chip-select is held low through reset, serial clocks produce no command byte until chip-select has gone high and then low again.
- R4: In an open frame, the first 8 rising serial-clock edges shift in a command byte, MSB first. It is reported with a one-cycle op_valid pulse. Later edges in the same frame report nothing.
- R5: A frame that closes with no rising serial-clock edge in it gives a one-cycle if_reset pulse. A frame that contains clock edges gives none.
- R6: The status byte is bit0 busy, bit1 write-enable latch, bit2 and bit3 the region-protect code (LSB at bit2), bit7 protect-enable, and bits 4 to 6 zero.
- R7: A wel_set pulse sets the write-enable latch when not busy.
- R8: An array write is granted only when the latch is set and busy is 0, and only if the region-protect code does not cover the address. The codes are: 00 covers nothing, 01 covers the top quarter, 10 covers the top half, 11 covers the whole array.
- R9: A status write is granted only when the latch is set, busy is 0, and protect-enable is 0 or wp_n is 1. A granted status write loads protect-enable from data bit 7 and the region code from data bits 3:2.
- R10: Any grant sets busy. A busy_done pulse while busy clears busy and the write-enable latch.
- R11: If both kinds of request arrive in the same cycle, only the status write can be granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| factory_init | input | 1 | Loads the default nonvolatile bits |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| wel_set | input | 1 | Request to set the write-enable latch |
| wr_req | input | 1 | Array write request |
| wr_addr | input | AW | Array write address |
| stat_wr_req | input | 1 | Status write request |
| stat_wr_data | input | 8 | Status write data |
| busy_done | input | 1 | End-of-write pulse |
| status | output | 8 | Status byte |
| arr_grant | output | 1 | Array write granted (pulse) |
| stat_grant | output | 1 | Status write granted (pulse) |
| op_valid | output | 1 | Command byte captured (pulse) |
| op_byte | output | 8 | Captured command byte |
| if_reset | output | 1 | Interface reset detected (pulse) |

## Verification
Grants and status changes follow a request one clock edge later, so the bench drives on a falling edge and samples on the next falling edge. The serial lines pass through a sampling register before edge detection. For that reason op_valid and if_reset appear on the second rising clock edge after the eighth serial-clock rise or the chip-select rise. Frame results are not tied to a fixed cycle. Each frame task queues the events it expects, and a monitor pops and compares them as they occur. Whatever is left in the queue at the end counts as missing.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_BP0  = 2;
  localparam int ST_BP1  = 3;
  localparam int ST_WPEN = 7;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_e;
endpackage

// File: rtl/spi_frame_trk.sv
module spi_frame_trk #(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           sck,
  input  logic           si,
  output logic           op_valid,
  output logic [OPW-1:0] op_byte,
  output logic           if_reset,
  output logic           active
);
  localparam int CW = $clog2(OPW + 1);

  logic cs_s, cs_d, sck_s, sck_d, si_s;
  logic seen;
  logic [CW-1:0]  cnt;
  logic [OPW-1:0] sh;

  wire cs_fall  = cs_d & ~cs_s;
  wire cs_rise  = ~cs_d & cs_s;
  wire sck_rise = sck_s & ~sck_d;

  // Both samples start low: a line held low through reset is not a falling edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_s <= 1'b0; cs_d <= 1'b0;
      sck_s <= 1'b0; sck_d <= 1'b0; si_s <= 1'b0;
    end else begin
      cs_s <= cs_n; cs_d <= cs_s;
      sck_s <= sck; sck_d <= sck_s; si_s <= si;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      seen     <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      op_valid <= 1'b0;
      op_byte  <= '0;
      if_reset <= 1'b0;
    end else begin
      op_valid <= 1'b0;
      if_reset <= 1'b0;
      if (cs_fall) begin
        active <= 1'b1;
        seen   <= 1'b0;
        cnt    <= '0;
      end else if (cs_rise) begin
        active <= 1'b0;
        if (active && !seen) if_reset <= 1'b1;
      end else if (active && sck_rise) begin
        seen <= 1'b1;
        if (cnt < CW'(OPW)) begin
          sh  <= {sh[OPW-2:0], si_s};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(OPW - 1)) begin
            op_valid <= 1'b1;
            op_byte  <= {sh[OPW-2:0], si_s};
          end
        end
      end
    end
  end

  assert_opv_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid);
  assert_ifrst_closed_R5: assert property (@(posedge clk) disable iff (rst)
    if_reset |-> !active);
endmodule

// File: rtl/spi_status_reg.sv
module spi_status_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       factory_init,
  input  logic       wel_set,
  input  logic       busy_done,
  input  logic       arr_go,
  input  logic       stat_go,
  input  logic [7:0] stat_data,
  output logic       busy,
  output logic       wel,
  output logic [1:0] bp,
  output logic       wpen
);
  import spi_ctl_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      wel  <= 1'b0;
    end else if (busy_done && busy) begin
      busy <= 1'b0;
      wel  <= 1'b0;
    end else if (arr_go || stat_go) begin
      busy <= 1'b1;
    end else if (wel_set && !busy) begin
      wel <= 1'b1;
    end
  end

  // Nonvolatile bits: deliberately outside the power-on reset.
  always_ff @(posedge clk) begin
    if (factory_init) begin
      wpen <= 1'b0;
      bp   <= PROT_NONE;
    end else if (stat_go) begin
      wpen <= stat_data[ST_WPEN];
      bp   <= {stat_data[ST_BP1], stat_data[ST_BP0]};
    end
  end

  assert_done_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_done && busy) |=> (!busy && !wel));
  assert_nv_keep_R1: assert property (@(posedge clk) disable iff (rst || factory_init)
    !stat_go |=> $stable({wpen, bp}));
endmodule

// File: rtl/spi_wp_dec.sv
module spi_wp_dec #(
  parameter int AW = 15
) (
  input  logic          busy,
  input  logic          wel,
  input  logic [1:0]    bp,
  input  logic          wpen,
  input  logic          wp_n,
  input  logic          arr_req,
  input  logic [AW-1:0] addr,
  input  logic          stat_req,
  output logic          arr_go,
  output logic          stat_go
);
  import spi_ctl_pkg::*;

  localparam logic [AW-1:0] HALF_BASE = {1'b1, {(AW-1){1'b0}}};
  localparam logic [AW-1:0] QTR_BASE  = {2'b11, {(AW-2){1'b0}}};

  logic locked;

  always_comb begin
    case (prot_e'(bp))
      PROT_NONE:    locked = 1'b0;
      PROT_QUARTER: locked = (addr >= QTR_BASE);
      PROT_HALF:    locked = (addr >= HALF_BASE);
      default:      locked = 1'b1;
    endcase
    stat_go = stat_req & ~busy & wel & (~wpen | wp_n);
    arr_go  = arr_req & ~stat_req & ~busy & wel & ~locked;
  end
endmodule

// File: rtl/spi_mem_ctl.sv
module spi_mem_ctl #(
  parameter int AW  = 15,
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           factory_init,
  input  logic           cs_n,
  input  logic           sck,
  input  logic           si,
  input  logic           wp_n,
  input  logic           wel_set,
  input  logic           wr_req,
  input  logic [AW-1:0]  wr_addr,
  input  logic           stat_wr_req,
  input  logic [7:0]     stat_wr_data,
  input  logic           busy_done,
  output logic [7:0]     status,
  output logic           arr_grant,
  output logic           stat_grant,
  output logic           op_valid,
  output logic [OPW-1:0] op_byte,
  output logic           if_reset
);
  import spi_ctl_pkg::*;

  logic busy, wel, wpen, arr_go, stat_go, active;
  logic [1:0] bp;

  spi_frame_trk #(.OPW(OPW)) u_frame (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .op_valid(op_valid), .op_byte(op_byte), .if_reset(if_reset), .active(active)
  );

  spi_wp_dec #(.AW(AW)) u_dec (
    .busy(busy), .wel(wel), .bp(bp), .wpen(wpen), .wp_n(wp_n),
    .arr_req(wr_req), .addr(wr_addr), .stat_req(stat_wr_req),
    .arr_go(arr_go), .stat_go(stat_go)
  );

  spi_status_reg u_stat (
    .clk(clk), .rst(rst), .factory_init(factory_init), .wel_set(wel_set),
    .busy_done(busy_done), .arr_go(arr_go), .stat_go(stat_go),
    .stat_data(stat_wr_data), .busy(busy), .wel(wel), .bp(bp), .wpen(wpen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_grant  <= 1'b0;
      stat_grant <= 1'b0;
    end else begin
      arr_grant  <= arr_go;
      stat_grant <= stat_go;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy;
    status[ST_WEL]  = wel;
    status[ST_BP0]  = bp[0];
    status[ST_BP1]  = bp[1];
    status[ST_WPEN] = wpen;
  end

  assert_grant_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(arr_grant && stat_grant));
  assert_grant_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (arr_grant || stat_grant) |-> status[ST_BUSY]);
endmodule

// File: tb/test_spi_mem_ctl.sv
module test_spi_mem_ctl;
  localparam int AW = 15;
  logic clk = 0, rst = 1, factory_init = 1;
  logic cs_n = 0, sck = 0, si = 0, wp_n = 1, wel_set = 0;
  logic wr_req = 0, stat_wr_req = 0, busy_done = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] stat_wr_data = '0, status, op_byte;
  logic arr_grant, stat_grant, op_valid, if_reset;
  int vectors = 0, miscmp = 0;
  bit finished = 0;
  logic [8:0] exq[$];

  always #2.5 clk = ~clk;

  spi_mem_ctl #(.AW(AW)) i_spi_mem_ctl (
    .clk(clk), .rst(rst), .factory_init(factory_init), .cs_n(cs_n), .sck(sck),
    .si(si), .wp_n(wp_n), .wel_set(wel_set), .wr_req(wr_req), .wr_addr(wr_addr),
    .stat_wr_req(stat_wr_req), .stat_wr_data(stat_wr_data), .busy_done(busy_done),
    .status(status), .arr_grant(arr_grant), .stat_grant(stat_grant),
    .op_valid(op_valid), .op_byte(op_byte), .if_reset(if_reset)
  );

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    vectors++;
    if (got !== exp) begin
      miscmp++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Monitor: pops the expected frame events (bit8: 1 = interface reset)
  always @(negedge clk) if (!rst) begin
    if (op_valid || if_reset) begin
      if (exq.size() == 0) chk("R4/R5 unexpected event", {if_reset, op_byte}, 9'h000);
      else chk("R4/R5 frame event", if_reset ? 9'h100 : {1'b0, op_byte}, exq.pop_front());
    end
  end

  task automatic half(); repeat (3) @(negedge clk); endtask

  task automatic frame(input logic [7:0] b, input int nbits);
    if (nbits >= 8) exq.push_back({1'b0, b});
    if (nbits == 0) exq.push_back(9'h100);
    @(negedge clk); cs_n = 0; half();
    for (int i = 0; i < nbits; i++) begin
      si = b[7 - (i % 8)]; half(); sck = 1; half(); sck = 0;
    end
    half(); cs_n = 1; repeat (6) @(negedge clk);
  endtask

  task automatic pulse_wel(); @(negedge clk); wel_set = 1; @(negedge clk); wel_set = 0; endtask
  task automatic pulse_done(); @(negedge clk); busy_done = 1; @(negedge clk); busy_done = 0; endtask

  task automatic arr_wr(input logic [AW-1:0] a, input logic exp, input string req);
    @(negedge clk); wr_req = 1; wr_addr = a;
    @(negedge clk); wr_req = 0;
    chk(req, {8'h0, arr_grant}, {8'h0, exp});
  endtask

  task automatic st_wr(input logic [7:0] d, input logic exp, input string req);
    @(negedge clk); stat_wr_req = 1; stat_wr_data = d;
    @(negedge clk); stat_wr_req = 0;
    chk(req, {8'h0, stat_grant}, {8'h0, exp});
  endtask

  task automatic st_is(input logic [7:0] e, input string req);
    @(negedge clk); chk(req, {1'b0, status}, {1'b0, e});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0; factory_init = 0;
    st_is(8'h00, "R1 R2 R6 reset state");
    chk("R1 no grant after reset", {7'h0, arr_grant, stat_grant}, 9'h0);
    // R3: CS held low through reset, clocks must not give a byte
    for (int i = 0; i < 8; i++) begin si = 1; half(); sck = 1; half(); sck = 0; end
    half(); cs_n = 1; repeat (6) @(negedge clk);
    frame(8'hA5, 8);   // R4 basic
    frame(8'h3C, 12);  // R4 extra clocks ignored
    frame(8'h00, 0);   // R5 interface reset
    frame(8'hFF, 3);   // R5 clocks present, no reset, no byte
    frame(8'h81, 8);   // R4 after partial frame
    // R8 / R7 / R10
    arr_wr(15'h0000, 0, "R8 no latch");
    pulse_wel(); st_is(8'h02, "R7 latch set");
    arr_wr(15'h1234, 1, "R8 granted");
    st_is(8'h03, "R10 busy set");
    arr_wr(15'h0001, 0, "R8 busy denies");
    pulse_wel(); st_is(8'h03, "R7 ignored while busy");
    pulse_done(); st_is(8'h00, "R10 done clears");
    // R9
    pulse_wel(); st_wr(8'h8C, 1, "R9 status write");
    st_is(8'h8F, "R9 R6 loaded");
    pulse_done(); st_is(8'h8C, "R10 done");
    pulse_wel(); arr_wr(15'h0000, 0, "R8 whole array locked");
    wp_n = 0; st_wr(8'h04, 0, "R9 pin blocks"); wp_n = 1;
    st_wr(8'h04, 1, "R9 pin high allows"); pulse_done(); st_is(8'h04, "R9 quarter code");
    pulse_wel(); arr_wr(15'h6000, 0, "R8 top quarter locked");
    arr_wr(15'h5FFF, 1, "R8 below quarter open"); pulse_done();
    pulse_wel(); st_wr(8'h08, 1, "R9 half code"); pulse_done();
    pulse_wel(); arr_wr(15'h4000, 0, "R8 top half locked");
    arr_wr(15'h3FFF, 1, "R8 lower half open"); pulse_done();
    // R11
    pulse_wel();
    @(negedge clk); wr_req = 1; wr_addr = 0; stat_wr_req = 1; stat_wr_data = 8'h08;
    @(negedge clk); wr_req = 0; stat_wr_req = 0;
    chk("R11 both requests", {7'h0, arr_grant, stat_grant}, 9'h001);
    pulse_done();
    // R1: nonvolatile bits survive reset, volatile cleared
    pulse_wel();
    @(negedge clk); rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    st_is(8'h08, "R1 protect bits kept");
    @(negedge clk); factory_init = 1; @(negedge clk); factory_init = 0;
    st_is(8'h00, "R2 factory defaults");
    repeat (4) @(negedge clk);
    chk("R4/R5 missing events", 9'(exq.size()), 9'h0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1; vectors++; miscmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end
endmodule